// File: doc/BRIEF.md
# Dispatch Throttle with Per-Reason Stall Counters

This block sits in the dispatch stage of an out-of-order core. Each clock is one machine cycle. In that cycle the front end offers at most one instruction, together with its micro-op count and a tag. The throttle decides whether the instruction leaves now. It checks two things: the dispatch bandwidth left in the cycle, and three resource indications. Those indications are a capacity flag from the rename mapping tracker, a slot flag from the retire queue, and a reason code from the scheduler.

An instruction with more micro-ops than the dispatch width takes the whole cycle. The micro-ops beyond the width become carry-over, which drains by one width per cycle.

On a dispatch the throttle asks the retire queue to reserve slots for the micro-op count. It takes the token the retire queue returns in that cycle and forwards it, with the tag, on a registered output one cycle later. When the bandwidth would allow the instruction but a resource is missing, the cause is charged to exactly one of six saturating 16-bit counters.

The bandwidth FSM has three states:
- `ST_FULL`: no carry-over, so all entries are available.
- `ST_BUSY`: the carry-over exceeds the width, so nothing may dispatch.
- `ST_TAIL`: the carry-over fits within one width. The remainder of that cycle stays open to a small instruction.

Its transitions are:
- `FULL->TAIL` or `FULL->BUSY`: a wide dispatch.
- `BUSY->BUSY` or `BUSY->TAIL`: drain by one width.
- `TAIL->FULL`: the carry-over is used up.
- `FULL->FULL`: a narrow dispatch or an idle cycle.

Top module: `dispatch_throttle`

## Requirements
- R1: After reset, `carry_uops` is 0, `avail_entries` equals the dispatch width (4 by default), `out_valid` is 0 and all six stall counters are 0.
- R2: An instruction with `in_uops` at most the dispatch width dispatches in the same cycle when all of these hold:
  - `in_uops` is no more than `avail_entries`;
  - `rename_ok` and `retire_ok` are high;
  - `sched_code` is 0.
  When it dispatches, `in_ready` and `rsv_valid` are high and `rsv_uops` equals `in_uops`. A zero-uop instruction consumes no entries.
- R3: An instruction with `in_uops` above the width dispatches only when `avail_entries` equals the full width. One cycle later, `carry_uops` equals `in_uops` minus the width.
- R4: While `carry_uops` exceeds the width, `avail_entries` is 0 and no instruction dispatches. Each cycle, `carry_uops` drops by the width.
- R5: While `carry_uops` is between 1 and the width, `avail_entries` is the width minus `carry_uops`. An instruction that fits into that remainder may dispatch. The next cycle, `carry_uops` is 0.
- R6: A stall is charged only when `in_valid` is high and the bandwidth would allow the instruction. If `rename_ok` is low in such a cycle, counter 0 (bits 15:0 of `stall_cnt`) increments.
- R7: If `rename_ok` is high and `retire_ok` is low in such a cycle, counter 1 (bits 31:16) increments.
- R8: With both flags high, a nonzero `sched_code` is charged to its own counter:
  - code 1 (scheduler queue full): counter 2;
  - code 2 (load queue full): counter 3;
  - code 3 (store queue full): counter 4;
  - code 4 (dispatch-group restriction): counter 5.
  Counter k occupies bits 16k+15 down to 16k.
- R9: At most one counter increments per cycle, with priority rename, then retire, then scheduler. No counter moves when the instruction is blocked by bandwidth, when `in_valid` is low, or when it dispatches.
- R10: A counter at 65535 stays at 65535 under further stalls.
- R11: In the cycle after a dispatch, `out_valid` is high, and `out_token` and `out_tag` equal the `rsv_token` and `in_tag` values of the dispatch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_uops | input | 4 | Micro-op count of the offered instruction |
| in_tag | input | 6 | Instruction tag |
| rename_ok | input | 1 | Rename mapping tracker has capacity |
| retire_ok | input | 1 | Retire queue has slots |
| sched_code | input | 3 | Scheduler verdict: 0 ok, 1 queue full, 2 load queue full, 3 store queue full, 4 group restriction |
| in_ready | output | 1 | Instruction dispatches this cycle |
| rsv_valid | output | 1 | Slot reservation request to the retire queue |
| rsv_uops | output | 4 | Micro-op count for the reservation |
| rsv_token | input | 5 | Token returned by the retire queue in the same cycle |
| out_valid | output | 1 | Registered dispatched-instruction valid |
| out_tag | output | 6 | Tag of the dispatched instruction |
| out_token | output | 5 | Retire queue token of the dispatched instruction |
| out_uops | output | 4 | Micro-op count of the dispatched instruction |
| avail_entries | output | 3 | Dispatch entries available this cycle |
| carry_uops | output | 4 | Outstanding carry-over micro-ops |
| stall_cnt | output | 96 | Six 16-bit saturating stall counters |

## Verification
The assertions assume that `sched_code` never takes a value above 4 while `in_valid` is high. They also assume that `rsv_token` is valid in any cycle where `rsv_valid` is high. The stimulus draws scheduler codes only from 0 to 4 and drives a token every cycle. It draws micro-op counts from 0 to 11, so instructions both narrower and wider than the width of 4 occur, together with carry-over of one to two extra cycles. A long directed run of rename stalls drives counter 0 into saturation.

// File: rtl/dt_pkg.sv
package dt_pkg;
    typedef enum logic [2:0] {
        SCH_OK    = 3'd0,
        SCH_QFULL = 3'd1,
        SCH_LDQ   = 3'd2,
        SCH_STQ   = 3'd3,
        SCH_GROUP = 3'd4
    } sched_code_e;

    typedef enum logic [1:0] {
        ST_FULL = 2'd0,
        ST_BUSY = 2'd1,
        ST_TAIL = 2'd2
    } bw_state_e;

    localparam int NUM_STALL = 6;
    localparam int IDX_RENAME = 0;
    localparam int IDX_RETIRE = 1;
    localparam int IDX_SCHED0 = 2;
endpackage

// File: rtl/dt_stall_ctr.sv
module dt_stall_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R9
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/dt_bandwidth.sv
module dt_bandwidth
    import dt_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    localparam int AW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UOP_W-1:0] req_uops,
    input  logic             take,
    output logic             fits,
    output logic [AW-1:0]    avail,
    output logic [UOP_W-1:0] carry,
    output bw_state_e        state
);
    localparam logic [UOP_W-1:0] WID_U = UOP_W'(WIDTH);
    localparam logic [AW-1:0]    WID_A = AW'(WIDTH);

    bw_state_e        state_q, state_n;
    logic [UOP_W-1:0] carry_q, carry_n;
    logic             wide;

    assign wide = (req_uops > WID_U);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            carry_q <= '0;
        end else begin
            state_q <= state_n;
            carry_q <= carry_n;
        end
    end

    // next state
    always_comb begin
        carry_n = carry_q;
        unique case (state_q)
            ST_FULL: carry_n = (take && wide) ? (req_uops - WID_U) : '0;
            ST_BUSY: carry_n = carry_q - WID_U;
            ST_TAIL: carry_n = '0;
            default: carry_n = '0;
        endcase
        if (carry_n == '0)
            state_n = ST_FULL;
        else if (carry_n > WID_U)
            state_n = ST_BUSY;
        else
            state_n = ST_TAIL;
    end

    // outputs
    always_comb begin
        avail = '0;
        fits  = 1'b0;
        unique case (state_q)
            ST_FULL: begin
                avail = WID_A;
                fits  = 1'b1;
            end
            ST_BUSY: begin
                avail = '0;
                fits  = 1'b0;
            end
            ST_TAIL: begin
                avail = WID_A - AW'(carry_q);
                fits  = !wide && (req_uops <= UOP_W'(avail));
            end
            default: begin
                avail = '0;
                fits  = 1'b0;
            end
        endcase
    end

    assign carry = carry_q;
    assign state = state_q;

    // R4
    busy_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> (carry_q == $past(carry_q) - WID_U));

    // R5
    tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |=> (carry_q == '0));
endmodule

// File: rtl/dispatch_throttle.sv
module dispatch_throttle
    import dt_pkg::*;
#(
    parameter int DISP_WIDTH = 4,
    parameter int UOP_W      = 4,
    parameter int TOKEN_W    = 5,
    parameter int TAG_W      = 6,
    parameter int CNT_W      = 16,
    localparam int AW        = $clog2(DISP_WIDTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [UOP_W-1:0]           in_uops,
    input  logic [TAG_W-1:0]           in_tag,
    input  logic                       rename_ok,
    input  logic                       retire_ok,
    input  logic [2:0]                 sched_code,
    output logic                       in_ready,
    output logic                       rsv_valid,
    output logic [UOP_W-1:0]           rsv_uops,
    input  logic [TOKEN_W-1:0]         rsv_token,
    output logic                       out_valid,
    output logic [TAG_W-1:0]           out_tag,
    output logic [TOKEN_W-1:0]         out_token,
    output logic [UOP_W-1:0]           out_uops,
    output logic [AW-1:0]              avail_entries,
    output logic [UOP_W-1:0]           carry_uops,
    output logic [NUM_STALL*CNT_W-1:0] stall_cnt
);
    localparam logic [UOP_W-1:0] WID_U = UOP_W'(DISP_WIDTH);

    logic                 bw_fits;
    logic                 res_ok;
    logic                 fire;
    logic [NUM_STALL-1:0] inc;
    bw_state_e            bw_state;

    dt_bandwidth #(
        .WIDTH (DISP_WIDTH),
        .UOP_W (UOP_W)
    ) bw_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_uops (in_uops),
        .take     (fire),
        .fits     (bw_fits),
        .avail    (avail_entries),
        .carry    (carry_uops),
        .state    (bw_state)
    );

    assign res_ok    = rename_ok && retire_ok && (sched_code == SCH_OK);
    assign fire      = in_valid && bw_fits && res_ok;
    assign in_ready  = fire;
    assign rsv_valid = fire;
    assign rsv_uops  = in_uops;

    // stall attribution, one reason per cycle
    always_comb begin
        inc = '0;
        if (in_valid && bw_fits) begin
            if (!rename_ok)
                inc[IDX_RENAME] = 1'b1;
            else if (!retire_ok)
                inc[IDX_RETIRE] = 1'b1;
            else begin
                unique case (sched_code)
                    SCH_QFULL: inc[IDX_SCHED0]     = 1'b1;
                    SCH_LDQ:   inc[IDX_SCHED0 + 1] = 1'b1;
                    SCH_STQ:   inc[IDX_SCHED0 + 2] = 1'b1;
                    SCH_GROUP: inc[IDX_SCHED0 + 3] = 1'b1;
                    default:   inc = '0;
                endcase
            end
        end
    end

    for (genvar k = 0; k < NUM_STALL; k++) begin : g_ctr
        dt_stall_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[k]),
            .cnt   (stall_cnt[k*CNT_W +: CNT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_token <= '0;
            out_uops  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_tag   <= in_tag;
                out_token <= rsv_token;
                out_uops  <= in_uops;
            end
        end
    end

    // R4
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_uops > WID_U) |-> !in_ready);

    // R3
    wide_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_uops > WID_U) |=> (carry_uops == $past(in_uops) - WID_U));

    // R11
    token_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (out_valid && out_token == $past(rsv_token) && out_tag == $past(in_tag)));

    // R9
    no_stall_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> $stable(stall_cnt));

    // R8
    sched_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (sched_code <= 3'd4));
endmodule

// File: tb/dispatch_throttle_tb_top.sv
module dispatch_throttle_tb_top;
    localparam int W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_uops = '0;
    logic [5:0]  in_tag = '0;
    logic        rename_ok = 1'b1;
    logic        retire_ok = 1'b1;
    logic [2:0]  sched_code = '0;
    logic        in_ready, rsv_valid, out_valid;
    logic [3:0]  rsv_uops, out_uops, carry_uops;
    logic [4:0]  rsv_token = '0;
    logic [5:0]  out_tag;
    logic [4:0]  out_token;
    logic [2:0]  avail_entries;
    logic [95:0] stall_cnt;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int carry_m = 0;
    int cnt_m[6];
    bit exp_ov = 1'b0;
    int exp_tag = 0;
    int exp_tok = 0;

    always #4 clk = ~clk;

    dispatch_throttle dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .in_tag(in_tag), .rename_ok(rename_ok), .retire_ok(retire_ok),
        .sched_code(sched_code), .in_ready(in_ready), .rsv_valid(rsv_valid),
        .rsv_uops(rsv_uops), .rsv_token(rsv_token), .out_valid(out_valid),
        .out_tag(out_tag), .out_token(out_token), .out_uops(out_uops),
        .avail_entries(avail_entries), .carry_uops(carry_uops), .stall_cnt(stall_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_avail(input int c);
        if (c == 0) return W;
        if (c > W) return 0;
        return W - c;
    endfunction

    function automatic bit m_fits(input int c, input int u);
        if (c > W) return 1'b0;
        if (u > W) return m_avail(c) == W;
        return u <= m_avail(c);
    endfunction

    function automatic string cnt_req(input int k);
        if (k == 0) return "R6";
        if (k == 1) return "R7";
        return "R8";
    endfunction

    task automatic step(input bit v, input int u, input int tag, input bit rn,
                        input bit rt, input int sc, input int tok);
        bit fits_m, fire_m;
        int idx;
        @(negedge clk);
        chk(int'(carry_uops) == carry_m, (carry_m > W) ? "R4" : "R5", carry_uops, carry_m);
        chk(out_valid == exp_ov, "R11", out_valid, exp_ov);
        if (exp_ov) begin
            chk(int'(out_token) == exp_tok, "R11", out_token, exp_tok);
            chk(int'(out_tag) == exp_tag, "R11", out_tag, exp_tag);
        end
        for (int k = 0; k < 6; k++)
            chk(int'(stall_cnt[k*16 +: 16]) == cnt_m[k], cnt_req(k), stall_cnt[k*16 +: 16], cnt_m[k]);
        in_valid = v; in_uops = 4'(u); in_tag = 6'(tag); rename_ok = rn;
        retire_ok = rt; sched_code = 3'(sc); rsv_token = 5'(tok);
        #1;
        fits_m = m_fits(carry_m, u);
        fire_m = v && fits_m && rn && rt && (sc == 0);
        chk(int'(avail_entries) == m_avail(carry_m),
            (carry_m > W) ? "R4" : (carry_m > 0) ? "R5" : "R2", avail_entries, m_avail(carry_m));
        chk(in_ready == fire_m, (u > W) ? "R3" : "R2", in_ready, fire_m);
        chk(rsv_valid == fire_m, "R2", rsv_valid, fire_m);
        if (fire_m) chk(int'(rsv_uops) == u, "R2", rsv_uops, u);
        // model update
        idx = -1;
        if (v && fits_m) begin
            if (!rn) idx = 0;
            else if (!rt) idx = 1;
            else if (sc != 0) idx = 1 + sc;
        end
        if (idx >= 0 && cnt_m[idx] < 65535) cnt_m[idx]++;
        exp_ov = fire_m;
        if (fire_m) begin exp_tag = tag; exp_tok = tok; end
        if (carry_m == 0) carry_m = (fire_m && u > W) ? u - W : 0;
        else if (carry_m > W) carry_m = carry_m - W;
        else carry_m = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'd2024));
        for (int k = 0; k < 6; k++) cnt_m[k] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(carry_uops == 0, "R1", carry_uops, 0);
        chk(int'(avail_entries) == W, "R1", avail_entries, W);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(stall_cnt == '0, "R1", 0, 0);

        // directed
        step(1, 3, 5, 1, 1, 0, 9);    // R2 narrow
        step(1, 10, 6, 1, 1, 0, 3);   // R3 wide, carry 6
        step(1, 1, 7, 1, 1, 0, 4);    // R4 busy blocked
        step(1, 3, 8, 1, 1, 0, 5);    // R5 tail avail 2, 3 blocked
        step(1, 9, 9, 1, 1, 0, 6);    // R3 carry 5
        step(1, 0, 10, 0, 1, 0, 7);   // R4 busy, no stall counted (R9)
        step(1, 1, 11, 1, 1, 0, 8);   // R5 tail avail 3, 1 dispatches
        step(1, 0, 12, 1, 1, 0, 2);   // R2 zero-uop
        step(1, 2, 13, 0, 0, 4, 1);   // R6 rename has priority
        step(1, 2, 14, 1, 0, 2, 1);   // R7
        step(1, 2, 15, 1, 1, 1, 1);   // R8 code 1
        step(1, 2, 16, 1, 1, 2, 1);   // R8 code 2
        step(1, 2, 17, 1, 1, 3, 1);   // R8 code 3
        step(1, 2, 18, 1, 1, 4, 1);   // R8 code 4
        step(0, 2, 19, 0, 0, 1, 1);   // R9 no valid, no count
        step(1, 6, 20, 0, 1, 0, 1);   // R6 wide with rename stall

        // random
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, $urandom % 12, $urandom % 64,
                 ($urandom % 5) != 0, ($urandom % 5) != 0,
                 (($urandom % 3) == 0) ? int'($urandom % 5) : 0, $urandom % 32);

        // R10 saturation of counter 0
        c0 = cnt_m[0];
        for (int i = 0; i < 65540 - c0; i++)
            step(1, 1, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        chk(int'(stall_cnt[15:0]) == 65535, "R10", stall_cnt[15:0], 65535);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule